// File: doc/BRIEF.md
# Multiplexed Display Serial Scanner

This block refreshes four multiplexed segment displays of twelve segments each. The displays hang off an external chain of two 8-bit serial-in, parallel-out registers that have a strobe latch. The block holds a 12-bit segment pattern for every digit. On each refresh tick it builds one 16-bit frame. That frame carries a one-hot digit-enable field and the segment pattern of the digit being lit. It clocks the frame out on a data line and a shift-clock line, then pulses a strobe so that the parallel outputs update together.

Successive frames step through the digits in a fixed order, so each digit is lit for one frame in four. The refresh period and the shift-clock divider are parameters. The defaults assume a 100 MHz clock, about 240 frames per second and a 2 MHz shift clock. The first frame after reset blanks the display.

Top module: `scan_display_driver`

## Requirements
- R1: While reset is asserted, sdata_o, sck_o and strobe_o are 0. The first frame latched after reset is all zeros.
- R2: A frame is 16 bits and is sent most-significant bit first. Bits 15..12 hold the digit-enable field and bits 11..0 hold the segment pattern, with pattern bit i at frame bit i.
- R3: The enable field of a non-blank frame is one-hot. Digit n sets bit 12+n to 1, and a 1 turns the digit on. The segment field is that digit's pattern word unchanged, where a 1 lights the segment.
- R4: After the blank frame, the digits are scanned in the order 0, 1, 2, 3 and then back to 0.
- R5: The data line holds steady while the shift clock is high. Each high phase lasts SCK_HALF clock cycles, so data is stable around every rising edge of the shift clock.
- R6: Strobe goes high only after the frame's last bit has been shifted. It stays high for exactly 2*SCK_HALF clock cycles, one shift-clock period, and the shift clock stays low the whole time.
- R7: Successive strobe pulses rise exactly REFRESH_CYC clock cycles apart.
- R8: The pattern of the digit being sent is sampled when its frame starts. A pattern change made after the first shift-clock edge of a frame does not alter that frame.
- R9: Every frame produces exactly 16 rising edges of the shift clock before its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_patterns_i | input | 48 | Segment patterns, digit n in bits [12n+11:12n] |
| sdata_o | output | 1 | Serial data to the register chain |
| sck_o | output | 1 | Shift clock; the register samples on its rising edge |
| strobe_o | output | 1 | Latch pulse that moves the shifted frame to the parallel outputs |

## Verification
The hardest case to reach from the ports is a pattern word changing while its own frame is still being shifted. The frame must keep the value that was captured when it started. The bench makes this happen on purpose. At the first shift-clock rise of every frame it records the pattern words and then overwrites them with new random values in the same sampling step. The frame then latched must match the recorded words and not the new ones. A second reset, asserted in the middle of a frame, checks that the blank frame and the digit-0 start come back after an interrupted shift.

// File: rtl/scan_pkg.sv
package scan_pkg;

   typedef enum logic [1:0] {
      SER_IDLE  = 2'd0,
      SER_LOW   = 2'd1,
      SER_HIGH  = 2'd2,
      SER_LATCH = 2'd3
   } ser_state_e;

   function automatic int unsigned scan_frame_width(input int unsigned digits,
                                                    input int unsigned seg_w);
      return digits + seg_w;
   endfunction

   function automatic int unsigned scan_min_period(input int unsigned frame_w,
                                                   input int unsigned sck_half);
      return (frame_w + 1) * 2 * sck_half + 2;
   endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
   parameter int unsigned PERIOD = 416667
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("scan_tick_gen: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = (cnt_q == CW'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = wrap;

endmodule

// File: rtl/scan_frame_builder.sv
module scan_frame_builder #(
   parameter int unsigned DIGITS = 4,
   parameter int unsigned SEG_W  = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         advance_i,
   input  logic [DIGITS-1:0][SEG_W-1:0] patterns_i,
   output logic [DIGITS+SEG_W-1:0]      frame_o
);
   localparam int unsigned DW = (DIGITS > 1) ? $clog2(DIGITS) : 1;

   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("scan_frame_builder: DIGITS must be at least 1");
      end
      if (SEG_W < 1) begin : g_bad_seg
         $error("scan_frame_builder: SEG_W must be at least 1");
      end
   endgenerate

   logic          blank_q;
   logic [DW-1:0] dig_q;
   logic [DIGITS-1:0] enable;
   logic [SEG_W-1:0]  seg_sel;

   // Digit pointer: a blank frame first, then the digits in ascending order.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blank_q <= 1'b1;
         dig_q   <= '0;
      end else if (advance_i) begin
         if (blank_q) begin
            blank_q <= 1'b0;
         end else if (dig_q == DW'(DIGITS - 1)) begin
            dig_q <= '0;
         end else begin
            dig_q <= dig_q + 1'b1;
         end
      end
   end

   // One-hot enable decode, one bit per digit.
   generate
      for (genvar d = 0; d < DIGITS; d++) begin : g_enable
         assign enable[d] = !blank_q && (dig_q == DW'(d));
      end
   endgenerate

   // AND-OR select of the lit digit's pattern.
   always_comb begin
      seg_sel = '0;
      for (int d = 0; d < DIGITS; d++) begin
         seg_sel = seg_sel | (patterns_i[d] & {SEG_W{enable[d]}});
      end
   end

   assign frame_o = {enable, seg_sel};

endmodule

// File: rtl/scan_serializer.sv
module scan_serializer
   import scan_pkg::*;
#(
   parameter int unsigned FRAME_W  = 16,
   parameter int unsigned SCK_HALF = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               sdata_o,
   output logic               sck_o,
   output logic               strobe_o
);
   localparam int unsigned LATCH_CYC = 2 * SCK_HALF;
   localparam int unsigned PW        = (LATCH_CYC > 2) ? $clog2(LATCH_CYC) : 1;
   localparam int unsigned BW        = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;

   generate
      if (SCK_HALF < 1) begin : g_bad_half
         $error("scan_serializer: SCK_HALF must be at least 1");
      end
      if (FRAME_W < 2) begin : g_bad_frame
         $error("scan_serializer: FRAME_W must be at least 2");
      end
   endgenerate

   ser_state_e        st_q;
   logic [FRAME_W-1:0] sh_q;
   logic [PW-1:0]     ph_q;
   logic [BW-1:0]     bit_q;
   logic              sck_q;
   logic              stb_q;
   logic              half_end;
   logic              latch_end;
   logic              last_bit;

   // Phase end: a single-cycle half period needs no comparator.
   generate
      if (SCK_HALF == 1) begin : g_half_one
         assign half_end = 1'b1;
      end else begin : g_half_cnt
         assign half_end = (ph_q == PW'(SCK_HALF - 1));
      end
   endgenerate

   assign latch_end = (ph_q == PW'(LATCH_CYC - 1));
   assign last_bit  = (bit_q == BW'(FRAME_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SER_IDLE;
         sh_q  <= '0;
         ph_q  <= '0;
         bit_q <= '0;
         sck_q <= 1'b0;
         stb_q <= 1'b0;
      end else begin
         case (st_q)
            SER_IDLE: begin
               if (start_i) begin
                  sh_q  <= frame_i;
                  ph_q  <= '0;
                  bit_q <= '0;
                  st_q  <= SER_LOW;
               end
            end
            SER_LOW: begin
               if (half_end) begin
                  ph_q  <= '0;
                  sck_q <= 1'b1;
                  st_q  <= SER_HIGH;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SER_HIGH: begin
               if (half_end) begin
                  ph_q  <= '0;
                  sck_q <= 1'b0;
                  sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                  if (last_bit) begin
                     stb_q <= 1'b1;
                     st_q  <= SER_LATCH;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                     st_q  <= SER_LOW;
                  end
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SER_LATCH: begin
               if (latch_end) begin
                  ph_q  <= '0;
                  stb_q <= 1'b0;
                  st_q  <= SER_IDLE;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: st_q <= SER_IDLE;
         endcase
      end
   end

   assign sdata_o  = ((st_q == SER_LOW) || (st_q == SER_HIGH)) && sh_q[FRAME_W-1];
   assign sck_o    = sck_q;
   assign strobe_o = stb_q;

endmodule

// File: rtl/scan_display_driver.sv
module scan_display_driver
   import scan_pkg::*;
#(
   parameter int unsigned DIGITS      = 4,
   parameter int unsigned SEG_W       = 12,
   parameter int unsigned SCK_HALF    = 25,
   parameter int unsigned REFRESH_CYC = 416667
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DIGITS-1:0][SEG_W-1:0] seg_patterns_i,
   output logic                         sdata_o,
   output logic                         sck_o,
   output logic                         strobe_o
);
   localparam int unsigned FRAME_W = scan_frame_width(DIGITS, SEG_W);
   localparam int unsigned MIN_PER = scan_min_period(FRAME_W, SCK_HALF);

   generate
      if (REFRESH_CYC < MIN_PER) begin : g_bad_refresh
         $error("scan_display_driver: REFRESH_CYC too short for one frame plus strobe");
      end
   endgenerate

   logic               tick;
   logic [FRAME_W-1:0] frame;

   scan_tick_gen #(
      .PERIOD(REFRESH_CYC)
   ) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_o(tick)
   );

   scan_frame_builder #(
      .DIGITS(DIGITS),
      .SEG_W (SEG_W)
   ) i_build (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (tick),
      .patterns_i(seg_patterns_i),
      .frame_o   (frame)
   );

   scan_serializer #(
      .FRAME_W (FRAME_W),
      .SCK_HALF(SCK_HALF)
   ) i_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tick),
      .frame_i (frame),
      .sdata_o (sdata_o),
      .sck_o   (sck_o),
      .strobe_o(strobe_o)
   );

endmodule

// File: rtl/scan_display_checker.sv
module scan_display_checker #(
   parameter int unsigned FRAME_W     = 16,
   parameter int unsigned DIGITS      = 4,
   parameter int unsigned REFRESH_CYC = 416667
) (
   input logic clk,
   input logic rst_n,
   input logic sdata_o,
   input logic sck_o,
   input logic strobe_o
);
   localparam int unsigned RW = $clog2(FRAME_W + 2) + 1;
   localparam int unsigned GW = $clog2(REFRESH_CYC + 2) + 1;

   logic               sck_d, stb_d, seen_q;
   logic [RW-1:0]      rises_q;
   logic [GW-1:0]      gap_q;
   logic [FRAME_W-1:0] shadow_q;
   logic               sck_rise, stb_rise;

   assign sck_rise = sck_o && !sck_d;
   assign stb_rise = strobe_o && !stb_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         stb_d    <= 1'b0;
         seen_q   <= 1'b0;
         rises_q  <= '0;
         gap_q    <= '0;
         shadow_q <= '0;
      end else begin
         sck_d <= sck_o;
         stb_d <= strobe_o;
         if (sck_rise) begin
            shadow_q <= {shadow_q[FRAME_W-2:0], sdata_o};
         end
         if (stb_rise) begin
            rises_q <= '0;
            gap_q   <= '0;
            seen_q  <= 1'b1;
         end else begin
            if (sck_rise && rises_q != '1) rises_q <= rises_q + 1'b1;
            if (gap_q != '1) gap_q <= gap_q + 1'b1;
         end
      end
   end

   // R5
   sck_high_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_o && sck_d) |-> $stable(sdata_o));

   // R6
   strobe_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> !sck_o);

   // R9
   strobe_after_full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rise |-> (rises_q == RW'(FRAME_W)));

   // R3
   enable_one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rise |-> $onehot0(shadow_q[FRAME_W-1 -: DIGITS]));

   // R7
   refresh_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_rise && seen_q) |-> (gap_q == GW'(REFRESH_CYC - 1)));

endmodule

bind scan_display_driver scan_display_checker #(
   .FRAME_W    (DIGITS + SEG_W),
   .DIGITS     (DIGITS),
   .REFRESH_CYC(REFRESH_CYC)
) i_scan_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sdata_o (sdata_o),
   .sck_o   (sck_o),
   .strobe_o(strobe_o)
);

// File: tb/test_scan_display_driver.sv
module test_scan_display_driver;
   localparam int unsigned DIGITS = 4;
   localparam int unsigned SEG_W  = 12;
   localparam int unsigned HALF   = 3;
   localparam int unsigned PER    = 120;
   localparam int unsigned FW     = DIGITS + SEG_W;
   localparam int unsigned LIMIT  = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DIGITS-1:0][SEG_W-1:0] pat = '0;
   logic sdata, sck, strobe;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int total_frames = 0;
   int rst_cycles = 0;

   // Bench model of the external register chain.
   logic prev_sck = 1'b0, prev_stb = 1'b0, prev_sdata = 1'b0;
   logic [FW-1:0] shadow = '0;
   logic [DIGITS-1:0][SEG_W-1:0] snap = '0;
   int rises = 0, hi_cnt = 0, stb_cnt = 0, gap = 0, fnum = 0;
   bit have_prev = 0, mutated = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   scan_display_driver #(
      .DIGITS(DIGITS), .SEG_W(SEG_W), .SCK_HALF(HALF), .REFRESH_CYC(PER)
   ) i_scan_display_driver (
      .clk(clk), .rst_n(rst_n), .seg_patterns_i(pat),
      .sdata_o(sdata), .sck_o(sck), .strobe_o(strobe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] exp_frame(input int n,
                                                input logic [DIGITS-1:0][SEG_W-1:0] p);
      logic [DIGITS-1:0] en;
      if (n == 0) return '0;
      en = '0;
      en[(n - 1) % DIGITS] = 1'b1;
      return {en, p[(n - 1) % DIGITS]};
   endfunction

   function automatic logic [DIGITS-1:0][SEG_W-1:0] next_pat(input int n);
      logic [DIGITS-1:0][SEG_W-1:0] r;
      for (int d = 0; d < DIGITS; d++) begin
         if (n < 4)       r[d] = '1;
         else if (n < 16) r[d] = SEG_W'(1) << ((n + d) % SEG_W);
         else if (n < 20) r[d] = '0;
         else             r[d] = SEG_W'($urandom);
      end
      return r;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         rst_cycles++;
         // R1: outputs quiet during reset
         if (rst_cycles == 2)
            check(!sdata && !sck && !strobe, "R1 reset outputs", {sdata, sck, strobe}, 0);
         prev_sck = 0; prev_stb = 0; prev_sdata = 0; shadow = '0;
         rises = 0; hi_cnt = 0; stb_cnt = 0; gap = 0; fnum = 0;
         have_prev = 0; mutated = 0;
      end else begin
         rst_cycles = 0;
         gap++;
         if (sck && !prev_sck) begin
            if (rises == 0) begin
               snap = pat;
               pat = next_pat(total_frames);
               mutated = (pat != snap);
            end
            shadow = {shadow[FW-2:0], sdata};
            rises++;
            hi_cnt = 1;
         end else if (sck && prev_sck) begin
            hi_cnt++;
            // R5: data steady while shift clock high
            check(sdata == prev_sdata, "R5 data stable", sdata, prev_sdata);
         end
         if (!sck && prev_sck)
            check(hi_cnt == HALF, "R5 high phase width", hi_cnt, HALF);
         if (strobe && !prev_stb) begin
            // R9: sixteen shift edges per frame
            check(rises == FW, "R9 edge count", rises, FW);
            if (fnum == 0)
               check(shadow == exp_frame(0, snap), "R1 blank first frame", shadow, 0);
            else if (mutated)
               check(shadow == exp_frame(fnum, snap), "R8 capture at frame start",
                     shadow, exp_frame(fnum, snap));
            else
               check(shadow == exp_frame(fnum, snap), "R2 R3 R4 frame content",
                     shadow, exp_frame(fnum, snap));
            // R7: strobe period
            if (have_prev) check(gap == PER, "R7 refresh interval", gap, PER);
            gap = 0; have_prev = 1; rises = 0; stb_cnt = 1;
            fnum++; total_frames++;
         end else if (strobe) begin
            stb_cnt++;
         end
         // R6: shift clock held low while strobe is high
         if (strobe && sck) check(0, "R6 sck low during strobe", sck, 0);
         if (!strobe && prev_stb)
            check(stb_cnt == 2 * HALF, "R6 strobe width", stb_cnt, 2 * HALF);
         prev_sck = sck; prev_stb = strobe; prev_sdata = sdata;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd20211);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      while (total_frames < 40 && cyc < LIMIT) @(negedge clk);
      // Second reset in the middle of a frame shift.
      while (!sck && cyc < LIMIT) @(negedge clk);
      repeat (7) @(negedge clk);
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      while (total_frames < 56 && cyc < LIMIT) @(negedge clk);
      if (cyc >= LIMIT) check(0, "watchdog", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule